// File: doc/BRIEF.md
# Gated Multi-Channel Pulse Former

This block turns sixteen digital "over threshold" inputs into sixteen output pulses of programmable length. A rising edge on a channel input starts a pulse. The pulse lasts a number of clock cycles derived from an 8-bit width code. One code serves channels 0 to 7, and a second code serves channels 8 to 15. Each channel has its own mode bit. In extend mode, a new edge during a pulse restarts the timer. In hold mode, a new edge during a pulse is ignored.

Three controls gate the channels. A per-channel enable mask silences a channel completely. A common veto discards input edges on every channel. A common test trigger fires every enabled channel at once. The test trigger is the OR of an external pin and a register strobe, and veto does not affect it. A single OR output reports whether any channel pulse is active. The block expects comparator results that are already synchronised to its clock.

Top module: `pulse_gate_top`

## Requirements
- R1: While `rstN` is low, every `pulseOut` bit and `orOut` are low.
- R2: A pulse lasts exactly MIN_CYC + floor(code × (MAX_CYC − MIN_CYC) / 255) cycles. For channels 0 to 7, code is `widthCodes[7:0]`; for channels 8 to 15, code is `widthCodes[15:8]`. With the defaults (2 and 10), code 0 gives 2 cycles and code 255 gives 10 cycles.
- R2 (latency): The clock edge that first samples a channel input high is the sampling edge. The pulse goes high on the clock edge after the sampling edge.
- R3: When a channel's `modeRetrig` bit is 0 (hold mode), an edge sampled while its pulse is high has no effect. This includes an edge that would load on the pulse's last high cycle. An edge that loads on the first low cycle starts a new pulse, so the output is low for exactly one cycle between the two pulses.
- R4: When a channel's `modeRetrig` bit is 1 (extend mode), an edge sampled while its pulse is high restarts the count. The output then stays high without a gap until the full width has elapsed after the latest edge.
- R5: Mode bits act per channel. Channels with different mode bits that receive the same input pattern behave as R3 and R4 state, each by its own bit.
- R6: A channel whose `chanEnable` bit is 0 never produces a pulse, neither from its input nor from the test trigger.
- R7: An input edge that is registered while `vetoIn` is registered high is discarded. This holds on every channel. The discarded edge does not cause a pulse later, even if the input stays high after veto drops.
- R8: A rising edge of (`testPin` OR `testStrobe`) fires every enabled channel, with the same latency as an input edge, whatever the level of `vetoIn`. A test level that stays high produces only one pulse.
- R9: `orOut` is high in exactly the cycles in which at least one `pulseOut` bit is high.
- R10: Clearing a channel's `chanEnable` bit during a pulse takes the output low from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitIn | input | NUM_CH | Synchronised over-threshold bits, one per channel |
| modeRetrig | input | NUM_CH | Per-channel mode: 1 = extend on retrigger, 0 = hold |
| chanEnable | input | NUM_CH | Per-channel enable mask, 1 = enabled |
| widthCodes | input | NUM_GRP*CODE_W | Width codes; bits [7:0] serve channels 0 to 7, bits [15:8] serve channels 8 to 15 |
| vetoIn | input | 1 | Common veto of input edges |
| testPin | input | 1 | External test trigger |
| testStrobe | input | 1 | Register-write test trigger |
| pulseOut | output | NUM_CH | Channel output pulses |
| orOut | output | 1 | OR of all channel pulses |

## Verification
A wrong down-counter value shows up as a pulse of the wrong length, with the error visible at the fall edge. At most MAX_CYC cycles pass after the load before it becomes visible. A stuck edge register shows as a missing or doubled pulse two cycles after the stimulus. A wrong mode decision shows only when a second edge lands inside a pulse. For that reason the bench times second edges to fall inside the pulse, on its last high cycle and on the first low cycle after it. A veto or mask fault shows as a pulse that should not exist, starting exactly two cycles after the offending edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // Per-channel command from control to datapath; clear wins over load.
  typedef struct packed {
    logic load;
    logic clear;
  } chStrobe_t;
endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl #(
  parameter int NUM_CH = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CH-1:0]               hitIn,
  input  logic                            vetoIn,
  input  logic                            testPin,
  input  logic                            testStrobe,
  input  logic [NUM_CH-1:0]               chanEnable,
  input  logic [NUM_CH-1:0]               modeRetrig,
  input  logic [NUM_CH-1:0]               active,
  output pg_pkg::chStrobe_t [NUM_CH-1:0]  strobes
);
  logic [NUM_CH-1:0] hitQ, hitPrev;
  logic              vetoQ, testQ, testPrev;
  logic [NUM_CH-1:0] hitRise, accepted, trigger;
  logic              testRise;

  // Input stage: veto and test are registered alongside the hit bits so
  // that an edge and the veto level are judged in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ     <= '0;
      hitPrev  <= '0;
      vetoQ    <= 1'b0;
      testQ    <= 1'b0;
      testPrev <= 1'b0;
    end else begin
      hitQ     <= hitIn;
      hitPrev  <= hitQ;
      vetoQ    <= vetoIn;
      testQ    <= testPin | testStrobe;
      testPrev <= testQ;
    end
  end

  always_comb begin
    hitRise  = hitQ & ~hitPrev;
    testRise = testQ & ~testPrev;
    accepted = hitRise & {NUM_CH{~vetoQ}};
    trigger  = chanEnable & (accepted | {NUM_CH{testRise}});
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_comb begin
      strobes[i].load  = trigger[i] & (~active[i] | modeRetrig[i]);
      strobes[i].clear = ~chanEnable[i];
    end
  end
endmodule

// File: rtl/pg_datapath.sv
module pg_datapath #(
  parameter int NUM_CH     = 16,
  parameter int GROUP_SIZE = 8,
  parameter int CODE_W     = 8,
  parameter int MIN_CYC    = 2,
  parameter int MAX_CYC    = 10
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  pg_pkg::chStrobe_t [NUM_CH-1:0]           strobes,
  input  logic [(NUM_CH/GROUP_SIZE)*CODE_W-1:0]    widthCodes,
  output logic [NUM_CH-1:0]                        active
);
  localparam int NUM_GRP  = NUM_CH / GROUP_SIZE;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int SPAN     = MAX_CYC - MIN_CYC;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] groupWidth [NUM_GRP];

  // Linear code-to-cycles map, one per channel group.
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [31:0] scaled;
    always_comb begin
      scaled        = (32'(widthCodes[g*CODE_W +: CODE_W]) * 32'(SPAN)) / 32'(CODE_MAX);
      groupWidth[g] = CNT_W'(scaled + 32'(MIN_CYC));
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam int GRP = i / GROUP_SIZE;
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 cnt <= '0;
      else if (strobes[i].clear) cnt <= '0;
      else if (strobes[i].load)  cnt <= groupWidth[GRP];
      else if (cnt != '0)        cnt <= cnt - 1'b1;
    end
    assign active[i] = (cnt != '0);
  end
endmodule

// File: rtl/pulse_gate_top.sv
module pulse_gate_top #(
  parameter int NUM_CH     = 16,
  parameter int GROUP_SIZE = 8,
  parameter int CODE_W     = 8,
  parameter int MIN_CYC    = 2,
  parameter int MAX_CYC    = 10,
  localparam int NUM_GRP   = NUM_CH / GROUP_SIZE
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CH-1:0]           hitIn,
  input  logic [NUM_CH-1:0]           modeRetrig,
  input  logic [NUM_CH-1:0]           chanEnable,
  input  logic [NUM_GRP*CODE_W-1:0]   widthCodes,
  input  logic                        vetoIn,
  input  logic                        testPin,
  input  logic                        testStrobe,
  output logic [NUM_CH-1:0]           pulseOut,
  output logic                        orOut
);
  pg_pkg::chStrobe_t [NUM_CH-1:0] strobes;
  logic [NUM_CH-1:0]              active;

  pg_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hitIn      (hitIn),
    .vetoIn     (vetoIn),
    .testPin    (testPin),
    .testStrobe (testStrobe),
    .chanEnable (chanEnable),
    .modeRetrig (modeRetrig),
    .active     (active),
    .strobes    (strobes)
  );

  pg_datapath #(
    .NUM_CH     (NUM_CH),
    .GROUP_SIZE (GROUP_SIZE),
    .CODE_W     (CODE_W),
    .MIN_CYC    (MIN_CYC),
    .MAX_CYC    (MAX_CYC)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .widthCodes (widthCodes),
    .active     (active)
  );

  assign pulseOut = active;
  assign orOut    = |active;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] hitIn,
  input logic [NUM_CH-1:0] chanEnable,
  input logic              vetoIn,
  input logic              testPin,
  input logic              testStrobe,
  input logic [NUM_CH-1:0] pulseOut,
  input logic              orOut
);
  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (pulseOut == '0 && !orOut);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6 / R10: a channel disabled in the previous cycle is low now.
    assert_masked_low_R6: assert property (@(posedge clk) disable iff (!rstN)
      !$past(chanEnable[i]) |-> !pulseOut[i]);

    // R8 / R2: every new pulse has an input or test cause two cycles back.
    assert_rise_has_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pulseOut[i]) |-> $past(hitIn[i] | testPin | testStrobe, 2));

    // R7: a pulse not caused by test never follows a vetoed sample.
    assert_veto_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(pulseOut[i]) && !$past(testPin | testStrobe, 2)) |-> !$past(vetoIn, 2));
  end
endmodule

bind pulse_gate_top pg_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hitIn      (hitIn),
  .chanEnable (chanEnable),
  .vetoIn     (vetoIn),
  .testPin    (testPin),
  .testStrobe (testStrobe),
  .pulseOut   (pulseOut),
  .orOut      (orOut)
);

// File: tb/pulse_gate_top_tb_top.sv
`timescale 1ns/1ps
module pulse_gate_top_tb_top;
  localparam int NCH  = 16;
  localparam int MINC = 2;
  localparam int MAXC = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] hitIn, modeRetrig, chanEnable, widthCodes;
  logic        vetoIn, testPin, testStrobe;
  logic [15:0] pulseOut;
  logic        orOut;

  int nChecks = 0;
  int nErr    = 0;
  logic [15:0] hist [0:39];

  always #2 clk = ~clk;

  pulse_gate_top #(
    .NUM_CH(NCH), .GROUP_SIZE(8), .CODE_W(8), .MIN_CYC(MINC), .MAX_CYC(MAXC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .modeRetrig(modeRetrig),
    .chanEnable(chanEnable), .widthCodes(widthCodes), .vetoIn(vetoIn),
    .testPin(testPin), .testStrobe(testStrobe), .pulseOut(pulseOut), .orOut(orOut)
  );

  function automatic int wOf(input int code);
    return MINC + (code * (MAXC - MINC)) / 255;
  endfunction

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Record outputs at sample s and check the OR relation (R9).
  task automatic sampleStep(input int s);
    hist[s] = pulseOut;
    checkEq("R9", "orOut vs any pulse", int'(orOut), int'(|pulseOut));
  endtask

  function automatic int firstHigh(input int ch, input int n);
    for (int s = 0; s < n; s++) if (hist[s][ch]) return s;
    return -1;
  endfunction

  function automatic int highCount(input int ch, input int n);
    int c = 0;
    for (int s = 0; s < n; s++) if (hist[s][ch]) c++;
    return c;
  endfunction

  initial begin
    #(4 * 150000);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    rstN = 1'b0; hitIn = '0; modeRetrig = '0; chanEnable = '1;
    widthCodes = '1; vetoIn = 1'b0; testPin = 1'b0; testStrobe = 1'b0;
    hitIn = 16'hFFFF; testPin = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checkEq("R1", "pulses in reset", int'(pulseOut), 0);
      checkEq("R1", "or in reset", int'(orOut), 0);
    end
    hitIn = '0; testPin = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1", "pulses after reset", int'(pulseOut), 0);

    // R2: sweep of both width codes, all channels hit together.
    for (int c = 0; c < 256; c++) begin
      widthCodes = {8'(255 - c), 8'(c)};
      for (int s = 0; s < 16; s++) begin
        sampleStep(s);
        hitIn = (s == 0) ? 16'hFFFF : 16'h0000;
        @(negedge clk);
      end
      for (int ch = 0; ch < NCH; ch++) begin
        checkEq("R2", "pulse start", firstHigh(ch, 16), 2);
        checkEq("R2", "pulse length", highCount(ch, 16), (ch < 8) ? wOf(c) : wOf(255 - c));
      end
    end

    // R3/R4/R5: second edge inside the pulse, mixed modes.
    widthCodes = 16'hFFFF; modeRetrig = 16'hAAAA;
    for (int s = 0; s < 24; s++) begin
      sampleStep(s);
      hitIn = (s == 0 || s == 5) ? 16'hFFFF : 16'h0000;
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      checkEq(ch[0] ? "R4" : "R3", "start mixed", firstHigh(ch, 24), 2);
      checkEq(ch[0] ? "R4" : "R5", "length mixed", highCount(ch, 24), ch[0] ? MAXC + 5 : MAXC);
    end

    // R3: edge loading on the last high cycle is ignored.
    modeRetrig = '0;
    for (int s = 0; s < 28; s++) begin
      sampleStep(s);
      hitIn = (s == 0 || s == MAXC) ? 16'hFFFF : 16'h0000;
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      checkEq("R3", "late edge ignored", highCount(ch, 28), MAXC);

    // R3: edge loading on the first low cycle re-arms with a one-cycle gap.
    for (int s = 0; s < 30; s++) begin
      sampleStep(s);
      hitIn = (s == 0 || s == 4 || s == MAXC + 1) ? 16'hFFFF : 16'h0000;
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      checkEq("R3", "re-arm total", highCount(ch, 30), 2 * MAXC);
      checkEq("R3", "one-cycle gap", int'(hist[MAXC + 2][ch]), 0);
    end

    // R6: masked channels stay silent for hit and test.
    chanEnable = 16'h0F3C;
    for (int s = 0; s < 34; s++) begin
      sampleStep(s);
      hitIn      = (s == 0) ? 16'hFFFF : 16'h0000;
      testStrobe = (s == 15);
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      checkEq("R6", "masked count", highCount(ch, 34), chanEnable[ch] ? 2 * MAXC : 0);
    chanEnable = '1;

    // R7: vetoed edge is discarded and never fires later.
    for (int s = 0; s < 20; s++) begin
      sampleStep(s);
      hitIn  = (s < 8) ? 16'hFFFF : 16'h0000;
      vetoIn = (s < 2);
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      checkEq("R7", "vetoed count", highCount(ch, 20), 0);

    // R8: test pin fires all channels despite veto.
    for (int s = 0; s < 16; s++) begin
      sampleStep(s);
      vetoIn  = (s < 6);
      testPin = (s == 0);
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      checkEq("R8", "test start", firstHigh(ch, 16), 2);
      checkEq("R8", "test length", highCount(ch, 16), MAXC);
    end

    // R8: held test strobe gives a single pulse even in extend mode.
    modeRetrig = '1;
    for (int s = 0; s < 24; s++) begin
      sampleStep(s);
      testStrobe = (s < 15);
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      checkEq("R8", "held test length", highCount(ch, 24), MAXC);
    modeRetrig = '0;

    // R10: disabling channel 3 mid-pulse cuts it at the next edge.
    for (int s = 0; s < 16; s++) begin
      sampleStep(s);
      hitIn = (s == 0) ? 16'hFFFF : 16'h0000;
      if (s == 5) chanEnable = 16'hFFF7;
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      checkEq("R10", "cut pulse length", highCount(ch, 16), (ch == 3) ? 4 : MAXC);
    chanEnable = '1;

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule